// File: doc/BRIEF.md
# Segmented Downward Stack Unit

This block keeps the stack pointer of a 16-bit segmented processor model and carries out every stack memory access that the processor needs. A request pushes a data word, pops a data word, or saves or restores a call frame. A near frame is one word holding a return offset. A far frame is two words holding a return offset and a return segment. The stack segment base comes from an input. The unit forms 20-bit physical addresses by shifting the segment left by four bits and adding the 16-bit stack pointer. Each word moves over a single-word memory port that uses a request/acknowledge handshake.

The stack grows toward lower offsets. Offset arithmetic wraps inside the 64K segment and never touches the segment base. The processor side waits until `busy` is low, presents one operation for one cycle, and picks up any popped or restored values when `done` pulses. Between operations the stack pointer can be loaded directly. The current top-of-stack physical address is always visible on an output.

Top module: `segStackUnit`

## Requirements
- R1: After reset `spOut` equals the SP_RESET parameter (default 0x0000), and `busy`, `done` and `memReq` are low.
- R2: A push (opCode 0) lowers the stack pointer by 2 and then writes `pushData` as a single word at the new top of stack.
- R3: A pop (opCode 1) reads the word at the current top of stack, returns it on `popData`, and then raises the stack pointer by 2.
- R4: Every memory address and `topAddr` equal segment×16 + offset, truncated to 20 bits, so a carry out of bit 19 is lost.
- R5: Stack pointer arithmetic wraps modulo 65536. A push at offset 0x0000 writes at offset 0xFFFE, and a pop at 0xFFFE leaves 0x0000.
- R6: A near call (opCode 2) pushes `callOff` as one word. A near return (opCode 4) pops one word into `retOff`.
- R7: A far call (opCode 3) writes `callSeg` at SP−2 and then `callOff` at SP−4, which leaves SP lowered by 4.
- R8: A far return (opCode 5) reads `retOff` at SP and then `retSeg` at SP+2, which leaves SP raised by 4.
- R9: `memReq` stays high with stable `memAddr`, `memWe` and `memWData` until `memAck`. Only one access is outstanding at a time.
- R10: `busy` is high from the cycle after acceptance until the final acknowledge. Requests made while busy are ignored. `done` pulses for one cycle right after the final acknowledge, and `busy` is already low in that cycle, so the next operation can be accepted then.
- R11: `loadSp` in an idle cycle with no accepted operation sets the stack pointer to `loadSpValue`. A load is ignored when an operation is accepted in the same cycle, and it is ignored while busy.
- R12: opCodes 6 and 7 are ignored. They start no access, leave the stack pointer unchanged and keep `busy` low.
- R13: `topAddr` follows the live `segBase` input. The memory accesses of an operation use the segment sampled when that operation was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request, taken when not busy |
| opCode | input | 3 | 0 push, 1 pop, 2 near call, 3 far call, 4 near return, 5 far return |
| pushData | input | 16 | Word stored by a push |
| callSeg | input | 16 | Return segment saved by a far call |
| callOff | input | 16 | Return offset saved by a call |
| loadSp | input | 1 | Direct stack pointer load |
| loadSpValue | input | 16 | Value for a direct load |
| segBase | input | 16 | Stack segment base |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| popData | output | 16 | Word returned by the last pop |
| retOff | output | 16 | Offset restored by the last return |
| retSeg | output | 16 | Segment restored by the last far return |
| spOut | output | 16 | Current stack pointer |
| topAddr | output | 20 | Physical top-of-stack address |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 20 | Physical access address |
| memWData | output | 16 | Write data |
| memRData | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Access completes this cycle |

## Verification
The completion pulse of one operation and the acceptance of the next can happen in the same cycle. The bench provokes this by presenting each new request in the very cycle where `done` is seen high. The scoreboard then requires the first access of the new operation to appear in order, at the address computed from the stack pointer the previous operation left behind. A second overlap is a direct load that arrives together with an accepted operation. It is judged from the final stack pointer, which must reflect only the operation.

// File: rtl/segStackPkg.sv
package segStackPkg;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALLN = 3'd2,
    OP_CALLF = 3'd3,
    OP_RETN  = 3'd4,
    OP_RETF  = 3'd5
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchIn;  // sample segment and write words at acceptance
    logic spDec;    // pointer down by one word
    logic spInc;    // pointer up by one word
    logic spLoad;   // direct load
    logic capPop;   // capture read word as popped data
    logic capOff;   // capture read word as return offset
    logic capSeg;   // capture read word as return segment
    logic second;   // second access of a two-word frame
  } pathStrobe_t;

  function automatic logic isWriteOp(input logic [2:0] code);
    return (code == OP_PUSH) || (code == OP_CALLN) || (code == OP_CALLF);
  endfunction

endpackage

// File: rtl/segStackCtrl.sv
module segStackCtrl
  import segStackPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic        loadSp,
  input  logic        memAck,
  output logic        busy,
  output logic        done,
  output logic        memReq,
  output logic        memWe,
  output pathStrobe_t stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} state_e;

  state_e  state, stateNext;
  opKind_e curOp;
  logic    codeOk, start, finish;

  assign codeOk = (opCode <= 3'd5);
  assign start  = opValid && (state == ST_IDLE) && codeOk;

  always_comb begin
    stb       = '0;
    stateNext = state;
    finish    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.latchIn = 1'b1;
          stb.spDec   = isWriteOp(opCode);
          stateNext   = ST_FIRST;
        end else if (loadSp) begin
          stb.spLoad = 1'b1;
        end
      end
      ST_FIRST: begin
        if (memAck) begin
          case (curOp)
            OP_POP: begin
              stb.capPop = 1'b1;
              stb.spInc  = 1'b1;
              finish     = 1'b1;
            end
            OP_RETN: begin
              stb.capOff = 1'b1;
              stb.spInc  = 1'b1;
              finish     = 1'b1;
            end
            OP_CALLF: begin
              stb.spDec = 1'b1;
              stateNext = ST_SECOND;
            end
            OP_RETF: begin
              stb.capOff = 1'b1;
              stb.spInc  = 1'b1;
              stateNext  = ST_SECOND;
            end
            default: finish = 1'b1;
          endcase
        end
      end
      ST_SECOND: begin
        stb.second = 1'b1;
        if (memAck) begin
          if (curOp == OP_RETF) begin
            stb.capSeg = 1'b1;
            stb.spInc  = 1'b1;
          end
          finish = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (finish) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curOp <= OP_PUSH;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finish;
      if (start) curOp <= opKind_e'(opCode);
    end
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = busy;
  assign memWe  = busy && isWriteOp(curOp);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/segStackPath.sv
module segStackPath
  import segStackPkg::*;
#(
  parameter int OFF_W = 16,
  parameter int SEG_SHIFT = 4,
  parameter int WORD_BYTES = 2,
  parameter logic [OFF_W-1:0] SP_RESET = '0,
  localparam int PHYS_W = OFF_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       stb,
  input  logic [2:0]        opCode,
  input  logic [OFF_W-1:0]  segBase,
  input  logic [OFF_W-1:0]  pushData,
  input  logic [OFF_W-1:0]  callSeg,
  input  logic [OFF_W-1:0]  callOff,
  input  logic [OFF_W-1:0]  loadSpValue,
  input  logic [OFF_W-1:0]  memRData,
  output logic [PHYS_W-1:0] memAddr,
  output logic [OFF_W-1:0]  memWData,
  output logic [PHYS_W-1:0] topAddr,
  output logic [OFF_W-1:0]  sp,
  output logic [OFF_W-1:0]  popData,
  output logic [OFF_W-1:0]  retOff,
  output logic [OFF_W-1:0]  retSeg
);

  localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

  logic [OFF_W-1:0] segReg, wordA, wordB, firstWord;

  function automatic logic [PHYS_W-1:0] toPhys(input logic [OFF_W-1:0] s,
                                               input logic [OFF_W-1:0] o);
    return {s, {SEG_SHIFT{1'b0}}} + PHYS_W'(o);
  endfunction

  always_comb begin
    case (opCode)
      OP_CALLN: firstWord = callOff;
      OP_CALLF: firstWord = callSeg;
      default:  firstWord = pushData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp <= SP_RESET;
    end else if (stb.spLoad) begin
      sp <= loadSpValue;
    end else if (stb.spDec) begin
      sp <= sp - STEP;
    end else if (stb.spInc) begin
      sp <= sp + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg  <= '0;
      wordA   <= '0;
      wordB   <= '0;
      popData <= '0;
      retOff  <= '0;
      retSeg  <= '0;
    end else begin
      if (stb.latchIn) begin
        segReg <= segBase;
        wordA  <= firstWord;
        wordB  <= callOff;
      end
      if (stb.capPop) popData <= memRData;
      if (stb.capOff) retOff  <= memRData;
      if (stb.capSeg) retSeg  <= memRData;
    end
  end

  assign memAddr  = toPhys(segReg, sp);
  assign memWData = stb.second ? wordB : wordA;
  assign topAddr  = toPhys(segBase, sp);

endmodule

// File: rtl/segStackUnit.sv
module segStackUnit
  import segStackPkg::*;
#(
  parameter int OFF_W = 16,
  parameter int SEG_SHIFT = 4,
  parameter int WORD_BYTES = 2,
  parameter logic [OFF_W-1:0] SP_RESET = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      opValid,
  input  logic [2:0]                opCode,
  input  logic [OFF_W-1:0]          pushData,
  input  logic [OFF_W-1:0]          callSeg,
  input  logic [OFF_W-1:0]          callOff,
  input  logic                      loadSp,
  input  logic [OFF_W-1:0]          loadSpValue,
  input  logic [OFF_W-1:0]          segBase,
  output logic                      busy,
  output logic                      done,
  output logic [OFF_W-1:0]          popData,
  output logic [OFF_W-1:0]          retOff,
  output logic [OFF_W-1:0]          retSeg,
  output logic [OFF_W-1:0]          spOut,
  output logic [OFF_W+SEG_SHIFT-1:0] topAddr,
  output logic                      memReq,
  output logic                      memWe,
  output logic [OFF_W+SEG_SHIFT-1:0] memAddr,
  output logic [OFF_W-1:0]          memWData,
  input  logic [OFF_W-1:0]          memRData,
  input  logic                      memAck
);

  localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

  pathStrobe_t stb;

  segStackCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .loadSp  (loadSp),
    .memAck  (memAck),
    .busy    (busy),
    .done    (done),
    .memReq  (memReq),
    .memWe   (memWe),
    .stb     (stb)
  );

  segStackPath #(
    .OFF_W      (OFF_W),
    .SEG_SHIFT  (SEG_SHIFT),
    .WORD_BYTES (WORD_BYTES),
    .SP_RESET   (SP_RESET)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .opCode      (opCode),
    .segBase     (segBase),
    .pushData    (pushData),
    .callSeg     (callSeg),
    .callOff     (callOff),
    .loadSpValue (loadSpValue),
    .memRData    (memRData),
    .memAddr     (memAddr),
    .memWData    (memWData),
    .topAddr     (topAddr),
    .sp          (spOut),
    .popData     (popData),
    .retOff      (retOff),
    .retSeg      (retSeg)
  );

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !busy && (opCode == OP_PUSH) |=> spOut == OFF_W'($past(spOut) - STEP));

  // R3
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |=> spOut == OFF_W'($past(spOut) + STEP));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWe) && $stable(memWData));

  // R12
  bad_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !busy && (opCode > 3'd5) && !loadSp |=> !busy && $stable(spOut));

endmodule

// File: tb/segStackUnit_bench.sv
module segStackUnit_bench;
  import segStackPkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [15:0] pushData = '0, callSeg = '0, callOff = '0;
  logic        loadSp = 1'b0;
  logic [15:0] loadSpValue = '0;
  logic [15:0] segBase = '0;
  logic        busy, done, memReq, memWe;
  logic [15:0] popData, retOff, retSeg, spOut, memWData;
  logic [19:0] topAddr, memAddr;
  logic [15:0] memRData = '0;
  logic        memAck = 1'b0;

  always #10 clk = ~clk;

  segStackUnit u_segStackUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .pushData(pushData), .callSeg(callSeg), .callOff(callOff),
    .loadSp(loadSp), .loadSpValue(loadSpValue), .segBase(segBase),
    .busy(busy), .done(done), .popData(popData), .retOff(retOff),
    .retSeg(retSeg), .spOut(spOut), .topAddr(topAddr), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck)
  );

  typedef struct {
    logic        we;
    logic [19:0] addr;
    logic [15:0] data;
    string       req;
  } access_t;

  access_t     expQ[$];
  logic [15:0] ram [logic [19:0]];
  int          checks = 0;
  int          errors = 0;
  int          ackDelay = 0;
  logic [15:0] expSp = '0;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: answers memory requests and compares them with the expected queue
  initial begin : responder
    int      cnt;
    access_t e;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        cnt = 0;
      end else if (memReq) begin
        if (cnt >= ackDelay) begin
          memAck = 1'b1;
          if (memWe) ram[memAddr] = memWData;
          memRData = ram.exists(memAddr) ? ram[memAddr] : 16'h0;
          if (expQ.size() == 0) begin
            check(1'b0, "R10", "unexpected access", {11'h0, memWe, memAddr}, 32'h0);
          end else begin
            e = expQ.pop_front();
            check(memWe == e.we && memAddr == e.addr, e.req, "access kind/address",
                  {11'h0, memWe, memAddr}, {11'h0, e.we, e.addr});
            if (e.we) check(memWData == e.data, e.req, "write data",
                            {16'h0, memWData}, {16'h0, e.data});
          end
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic issue(input logic [2:0] code, input logic [15:0] pd,
                       input logic [15:0] cs, input logic [15:0] co);
    while (busy) @(negedge clk);
    opCode = code; pushData = pd; callSeg = cs; callOff = co; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, req, "done pulse", {31'h0, done}, 32'h1);
    check(busy == 1'b0, "R10", "busy low with done", {31'h0, busy}, 32'h0);
  endtask

  task automatic doPush(input logic [15:0] v, input string req);
    expSp = expSp - 16'd2;
    expQ.push_back('{1'b1, phys(segBase, expSp), v, req});
    issue(3'd0, v, 16'h0, 16'h0);
    waitDone(req);
    check(spOut == expSp, req, "sp after push", {16'h0, spOut}, {16'h0, expSp});
  endtask

  task automatic doPop(input logic [15:0] v, input string req);
    expQ.push_back('{1'b0, phys(segBase, expSp), 16'h0, req});
    issue(3'd1, 16'h0, 16'h0, 16'h0);
    waitDone(req);
    expSp = expSp + 16'd2;
    check(popData == v, req, "popped word", {16'h0, popData}, {16'h0, v});
    check(spOut == expSp, req, "sp after pop", {16'h0, spOut}, {16'h0, expSp});
  endtask

  task automatic farCall(input logic [15:0] cs, input logic [15:0] co,
                         input logic [15:0] segAfter);
    expQ.push_back('{1'b1, phys(segBase, expSp - 16'd2), cs, "R7"});
    expQ.push_back('{1'b1, phys(segBase, expSp - 16'd4), co, "R7"});
    expSp = expSp - 16'd4;
    issue(3'd3, 16'h0, cs, co);
    segBase = segAfter;
    waitDone("R7");
    check(spOut == expSp, "R7", "sp after far call", {16'h0, spOut}, {16'h0, expSp});
  endtask

  task automatic farRet(input logic [15:0] co, input logic [15:0] cs);
    expQ.push_back('{1'b0, phys(segBase, expSp), 16'h0, "R8"});
    expQ.push_back('{1'b0, phys(segBase, expSp + 16'd2), 16'h0, "R8"});
    expSp = expSp + 16'd4;
    issue(3'd5, 16'h0, 16'h0, 16'h0);
    waitDone("R8");
    check(retOff == co, "R8", "restored offset", {16'h0, retOff}, {16'h0, co});
    check(retSeg == cs, "R8", "restored segment", {16'h0, retSeg}, {16'h0, cs});
    check(spOut == expSp, "R8", "sp after far return", {16'h0, spOut}, {16'h0, expSp});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spOut == 16'h0, "R1", "reset sp", {16'h0, spOut}, 32'h0);
    check({busy, done, memReq} == 3'b000, "R1", "reset flags",
          {29'h0, busy, done, memReq}, 32'h0);

    segBase = 16'h2000;
    // R11 direct load while idle
    loadSp = 1'b1; loadSpValue = 16'h0100;
    @(negedge clk);
    loadSp = 1'b0;
    expSp = 16'h0100;
    check(spOut == expSp, "R11", "loaded sp", {16'h0, spOut}, {16'h0, expSp});
    // R13 live segment on topAddr
    check(topAddr == phys(segBase, expSp), "R13", "topAddr",
          {12'h0, topAddr}, {12'h0, phys(segBase, expSp)});

    // R2/R3 back-to-back: next op starts in the done cycle (R10)
    ackDelay = 0;
    doPush(16'h1111, "R2");
    doPush(16'h2222, "R2");
    doPop(16'h2222, "R3");
    doPop(16'h1111, "R3");

    // R6 near frame with wait states
    ackDelay = 2;
    expSp = expSp - 16'd2;
    expQ.push_back('{1'b1, phys(segBase, expSp), 16'hABCD, "R6"});
    issue(3'd2, 16'h0, 16'h0, 16'hABCD);
    waitDone("R6");
    check(spOut == expSp, "R6", "sp after near call", {16'h0, spOut}, {16'h0, expSp});
    expQ.push_back('{1'b0, phys(segBase, expSp), 16'h0, "R6"});
    issue(3'd4, 16'h0, 16'h0, 16'h0);
    waitDone("R6");
    expSp = expSp + 16'd2;
    check(retOff == 16'hABCD, "R6", "near return offset", {16'h0, retOff}, 32'hABCD);

    // R7/R13 far call, segment input changes while busy
    farCall(16'h3456, 16'h789A, 16'h5000);
    check(topAddr == phys(16'h5000, expSp), "R13", "topAddr follows live segment",
          {12'h0, topAddr}, {12'h0, phys(16'h5000, expSp)});
    segBase = 16'h2000;
    farRet(16'h789A, 16'h3456);

    // R10 requests while busy are ignored
    farCall(16'h0A0A, 16'h0B0B, 16'h2000);
    expQ.push_back('{1'b1, phys(segBase, expSp - 16'd2), 16'h0C0C, "R10"});
    expSp = expSp - 16'd2;
    issue(3'd0, 16'h0C0C, 16'h0, 16'h0);
    opValid = 1'b1; opCode = 3'd1;
    check(busy == 1'b1, "R10", "busy during op", {31'h0, busy}, 32'h1);
    @(negedge clk);
    check(busy == 1'b1, "R10", "busy during op", {31'h0, busy}, 32'h1);
    opValid = 1'b0;
    waitDone("R10");
    check(spOut == expSp, "R10", "sp unaffected by ignored request",
          {16'h0, spOut}, {16'h0, expSp});
    doPop(16'h0C0C, "R10");
    farRet(16'h0B0B, 16'h0A0A);

    // R12 unused codes
    opCode = 3'd6; opValid = 1'b1;
    @(negedge clk);
    opCode = 3'd7;
    @(negedge clk);
    opValid = 1'b0;
    check({busy, memReq} == 2'b00, "R12", "no activity", {30'h0, busy, memReq}, 32'h0);
    check(spOut == expSp, "R12", "sp unchanged", {16'h0, spOut}, {16'h0, expSp});

    // R11 load together with an accepted op, then during busy
    ackDelay = 1;
    loadSp = 1'b1; loadSpValue = 16'h4444;
    expSp = expSp - 16'd2;
    expQ.push_back('{1'b1, phys(segBase, expSp), 16'h7777, "R11"});
    issue(3'd0, 16'h7777, 16'h0, 16'h0);
    loadSp = 1'b1;
    @(negedge clk);
    loadSp = 1'b0;
    waitDone("R11");
    check(spOut == expSp, "R11", "load ignored with op and while busy",
          {16'h0, spOut}, {16'h0, expSp});
    doPop(16'h7777, "R11");

    // R5 wrap at the bottom of the segment
    loadSp = 1'b1; loadSpValue = 16'h0000;
    @(negedge clk);
    loadSp = 1'b0;
    expSp = 16'h0000;
    doPush(16'h5A5A, "R5");
    check(spOut == 16'hFFFE, "R5", "wrapped sp", {16'h0, spOut}, 32'hFFFE);
    doPop(16'h5A5A, "R5");

    // R4 carry out of bit 19 dropped
    segBase = 16'hFFFF;
    loadSp = 1'b1; loadSpValue = 16'h0020;
    @(negedge clk);
    loadSp = 1'b0;
    expSp = 16'h0020;
    doPush(16'h0F0F, "R4");
    check(topAddr == 20'h0000E, "R4", "truncated address", {12'h0, topAddr}, 32'h0000E);
    doPop(16'h0F0F, "R4");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9", "all expected accesses seen", expQ.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule